// File: doc/BRIEF.md
# Host-Fed ATM Cell Insertion Buffer

This block lets a host processor build complete ATM cells in a small on-chip store and hand them to a receive cell stream. The host writes each cell as fourteen 32-bit words carrying 56 bytes: four header bytes, one HEC byte, three user-defined bytes and forty-eight payload bytes. Before the first word of a cell, the host sets a start marker in an 8-bit control register. A room flag in the same register tells it whether a whole cell slot is free.

Cells become visible on the stream side only once all fourteen words are written. They leave through a valid/ready port one word per accepted transfer, with a start flag on each cell's first word. An active-low flush bit, written 0 and then 1, empties the store. While the bit is 0, host data is ignored and the output stays idle. Trying to start a cell with no room drops that cell and sets a sticky overflow flag, which only a flush clears.

Top module: `cell_insert_buf`

## Requirements
- R1: After reset the control register reads 0x06 (bit 2 flush_n = 1, bit 1 room = 1, all other bits 0) and out_valid is 0.
- R2: A cell is never offered on the output before its 14th word has been written; after 13 words out_valid and the cell-available bit 4 stay 0, and after the 14th they are 1.
- R3: Bit 1 (room) reads 1 exactly when fewer than 4 complete cells are held. Bit 4 (cell available) reads 1 exactly when at least one complete cell is held.
- R4: A marked word written while room is 0 is dropped and sets overflow bit 3, which stays 1 until a flush.
- R5: While bit 2 is 0, out_valid is 0 and data writes have no effect. After the bit returns to 1 the buffer is empty and bit 3 is 0.
- R6: While out_valid is 1 and out_ready is 0, out_valid, out_data and out_soc hold their values.
- R7: out_soc is 1 exactly on the first word of each cell. One word advances per cycle with out_valid and out_ready both 1, and cells leave in the order they were completed.
- R8: Words leave unchanged and in written order, big-endian. Word 0 holds header bytes 0..3 with byte 0 in bits 31:24. Word 1 holds the HEC in bits 31:24 and the user bytes below it. Words 2..13 hold the payload.
- R9: Bit 0 (start marker) reads back as written and is cleared by the data write that uses it.
- R10: A marked word written while a partial cell is pending discards the partial cell and starts a new one in its place.
- R11: A data word written when no cell is open and the marker is clear is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write value |
| reg_rdata | output | 8 | Control/status register read value |
| dat_wr | input | 1 | Host data word write strobe |
| dat_wdata | input | 32 | Host data word |
| out_valid | output | 1 | A cell word is offered |
| out_ready | input | 1 | Stream side accepts the word |
| out_data | output | 32 | Cell word |
| out_soc | output | 1 | First word of a cell |

## Verification
Fill levels of one to four cells are swept, each drained under a different ready pattern. This separates the room and availability thresholds and checks that stalls do not skip or repeat words. A byte-numbered cell shows the big-endian field placement, and per-cell, per-word data values show cell ordering across pointer wrap. Further sequences cover an abandoned partial cell followed by a fresh marker, words with no open cell, a start attempt on a full buffer, and writes made during a flush. Each of these must leave the output and status bits in a distinct state.

// File: rtl/cib_pkg.sv
package cib_pkg;
   // Control/status register bit positions
   localparam int BIT_SOC     = 0;  // start marker, read/write, cleared on use
   localparam int BIT_ROOM    = 1;  // read-only: a complete slot is free
   localparam int BIT_FLUSH_N = 2;  // read/write, active-low flush
   localparam int BIT_OVF     = 3;  // read-only sticky overflow
   localparam int BIT_AVAIL   = 4;  // read-only: a complete cell is held
   localparam int REG_MIN_W   = 5;
endpackage

// File: rtl/cib_ctrl_reg.sv
module cib_ctrl_reg
   import cib_pkg::*;
#(
   parameter int REG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [REG_W-1:0] reg_wdata,
   input  logic             marker_take,
   input  logic             ovf_set,
   input  logic             room,
   input  logic             avail,
   output logic             marker,
   output logic             flush_n,
   output logic [REG_W-1:0] reg_rdata
);
   logic ovf;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         marker  <= 1'b0;
         flush_n <= 1'b1;
      end else if (reg_wr) begin
         marker  <= reg_wdata[BIT_SOC];
         flush_n <= reg_wdata[BIT_FLUSH_N];
      end else if (marker_take) begin
         marker  <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ovf <= 1'b0;
      else if (!flush_n) ovf <= 1'b0;
      else if (ovf_set)  ovf <= 1'b1;
   end

   always_comb begin
      reg_rdata              = '0;
      reg_rdata[BIT_SOC]     = marker;
      reg_rdata[BIT_ROOM]    = room;
      reg_rdata[BIT_FLUSH_N] = flush_n;
      reg_rdata[BIT_OVF]     = ovf;
      reg_rdata[BIT_AVAIL]   = avail;
   end
endmodule

// File: rtl/cib_writer.sv
module cib_writer #(
   parameter int WORDS = 14,
   localparam int WIW  = $clog2(WORDS)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           flush_n,
   input  logic           dat_wr,
   input  logic           marker,
   input  logic           room,
   output logic           marker_take,
   output logic           ovf_set,
   output logic           wr_en,
   output logic [WIW-1:0] wr_idx,
   output logic           commit
);
   logic           open;
   logic [WIW-1:0] wcnt;
   logic           start, cont, last;

   assign marker_take = dat_wr && flush_n && marker;
   assign start       = marker_take && room;
   assign ovf_set     = marker_take && !room;
   assign cont        = dat_wr && flush_n && !marker && open;
   assign last        = (wcnt == WIW'(WORDS - 1));
   assign wr_en       = start || cont;
   assign wr_idx      = start ? '0 : wcnt;
   assign commit      = cont && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open <= 1'b0;
         wcnt <= '0;
      end else if (!flush_n) begin
         open <= 1'b0;
         wcnt <= '0;
      end else if (start) begin
         open <= 1'b1;
         wcnt <= WIW'(1);
      end else if (ovf_set) begin
         open <= 1'b0;
         wcnt <= '0;
      end else if (cont) begin
         if (last) begin
            open <= 1'b0;
            wcnt <= '0;
         end else begin
            wcnt <= wcnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/cib_store.sv
module cib_store #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 4,
   parameter int WORDS  = 14,
   localparam int WIW   = $clog2(WORDS),
   localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_n,
   input  logic              wr_en,
   input  logic [WIW-1:0]    wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              commit,
   input  logic              out_ready,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              out_soc,
   output logic              room,
   output logic              avail
);
   logic [DATA_W-1:0] mem [DEPTH][WORDS];
   logic [PW-1:0]     wr_ptr, rd_ptr, wr_ptr_nx, rd_ptr_nx;
   logic [WIW-1:0]    rd_w;
   logic [CW-1:0]     count;
   logic              pop, pop_last;

   generate
      if (DEPTH == 1) begin : g_single
         assign wr_ptr_nx = '0;
         assign rd_ptr_nx = '0;
      end else if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_ptr_nx = wr_ptr + 1'b1;
         assign rd_ptr_nx = rd_ptr + 1'b1;
      end else begin : g_wrap
         assign wr_ptr_nx = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_ptr_nx = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_ptr][wr_idx] <= wr_data;
   end

   assign avail     = (count != '0);
   assign room      = (count < CW'(DEPTH));
   assign out_valid = flush_n && avail;
   assign out_data  = mem[rd_ptr][rd_w];
   assign out_soc   = (rd_w == '0);
   assign pop       = out_valid && out_ready;
   assign pop_last  = pop && (rd_w == WIW'(WORDS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         rd_w   <= '0;
         count  <= '0;
      end else if (!flush_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         rd_w   <= '0;
         count  <= '0;
      end else begin
         if (commit) wr_ptr <= wr_ptr_nx;
         if (pop) begin
            if (pop_last) begin
               rd_w   <= '0;
               rd_ptr <= rd_ptr_nx;
            end else begin
               rd_w   <= rd_w + 1'b1;
            end
         end
         case ({commit, pop_last})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/cell_insert_buf.sv
module cell_insert_buf
   import cib_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int CELL_BYTES  = 56,
   parameter int DEPTH_CELLS = 4,
   parameter int REG_W       = 8,
   localparam int WORDS_PER_CELL = CELL_BYTES / (DATA_W / 8),
   localparam int WIW            = $clog2(WORDS_PER_CELL)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              dat_wr,
   input  logic [DATA_W-1:0] dat_wdata,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              out_soc
);
   generate
      if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_width
         $error("DATA_W must be a whole number of bytes");
      end
      if (CELL_BYTES % (DATA_W / 8) != 0) begin : g_bad_cell
         $error("CELL_BYTES must be a whole number of words");
      end
      if (WORDS_PER_CELL < 2) begin : g_bad_words
         $error("a cell needs at least two words");
      end
      if (DEPTH_CELLS < 1) begin : g_bad_depth
         $error("DEPTH_CELLS must be at least 1");
      end
      if (REG_W < REG_MIN_W) begin : g_bad_reg
         $error("REG_W too narrow for the status bits");
      end
   endgenerate

   logic           marker, flush_n, marker_take, ovf_set;
   logic           room, avail, wr_en, commit;
   logic [WIW-1:0] wr_idx;

   cib_ctrl_reg #(.REG_W(REG_W)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .reg_wr      (reg_wr),
      .reg_wdata   (reg_wdata),
      .marker_take (marker_take),
      .ovf_set     (ovf_set),
      .room        (room),
      .avail       (avail),
      .marker      (marker),
      .flush_n     (flush_n),
      .reg_rdata   (reg_rdata)
   );

   cib_writer #(.WORDS(WORDS_PER_CELL)) u_writer (
      .clk         (clk),
      .rst_n       (rst_n),
      .flush_n     (flush_n),
      .dat_wr      (dat_wr),
      .marker      (marker),
      .room        (room),
      .marker_take (marker_take),
      .ovf_set     (ovf_set),
      .wr_en       (wr_en),
      .wr_idx      (wr_idx),
      .commit      (commit)
   );

   cib_store #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH_CELLS),
      .WORDS  (WORDS_PER_CELL)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush_n   (flush_n),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_data   (dat_wdata),
      .commit    (commit),
      .out_ready (out_ready),
      .out_valid (out_valid),
      .out_data  (out_data),
      .out_soc   (out_soc),
      .room      (room),
      .avail     (avail)
   );
endmodule

// File: rtl/cib_checker.sv
module cib_checker
   import cib_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int REG_W  = 8,
   parameter int WORDS  = 14,
   localparam int WIW   = $clog2(WORDS)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [REG_W-1:0]  reg_rdata,
   input logic              dat_wr,
   input logic              out_valid,
   input logic              out_ready,
   input logic [DATA_W-1:0] out_data,
   input logic              out_soc
);
   logic [WIW-1:0] seen;

   // Words accepted so far within the current outgoing cell
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         seen <= '0;
      else if (!reg_rdata[BIT_FLUSH_N])   seen <= '0;
      else if (out_valid && out_ready)
         seen <= (seen == WIW'(WORDS - 1)) ? '0 : seen + 1'b1;
   end

   // R2: a cell appears only right after a host data write completed it
   p_valid_needs_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(dat_wr));

   // R4: overflow stays set while no flush is requested
   p_overflow_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[BIT_OVF] && reg_rdata[BIT_FLUSH_N]) |=> reg_rdata[BIT_OVF]);

   // R5: flush keeps the output idle and leaves it empty afterwards
   p_flush_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rdata[BIT_FLUSH_N] |=> !out_valid);

   // R6: a stalled word is held
   p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && !reg_wr) |=>
         (out_valid && $stable(out_data) && $stable(out_soc)));

   // R7: start flag marks exactly the first word of each cell
   p_soc_framing_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_soc == (seen == '0)));
endmodule

bind cell_insert_buf cib_checker #(
   .DATA_W (DATA_W),
   .REG_W  (REG_W),
   .WORDS  (WORDS_PER_CELL)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_rdata (reg_rdata),
   .dat_wr    (dat_wr),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data),
   .out_soc   (out_soc)
);

// File: tb/cell_insert_buf_tb.sv
module cell_insert_buf_tb;
   localparam int NW = 14;
   localparam int ND = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        dat_wr = 1'b0;
   logic [31:0] dat_wdata = '0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [31:0] out_data;
   logic        out_soc;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   cell_insert_buf u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .dat_wr(dat_wr), .dat_wdata(dat_wdata),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_soc(out_soc));

   function automatic logic [7:0] cell_byte(int i);
      if (i < 4)      return 8'(8'h10 + i);   // header
      else if (i == 4) return 8'h55;          // HEC
      else if (i < 8) return 8'(8'hE0 + i - 5); // user-defined
      else            return 8'(i - 8);         // payload
   endfunction

   function automatic logic [31:0] exp_word(int id, int w);
      if (id == 255)
         return {cell_byte(4*w), cell_byte(4*w+1), cell_byte(4*w+2), cell_byte(4*w+3)};
      return {8'(id), 8'h5A, 8'(w), 8'(w * 3 + id)};
   endfunction

   task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic reg_write(logic [7:0] v);
      @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic word_write(logic [31:0] d);
      @(negedge clk); dat_wr = 1'b1; dat_wdata = d;
      @(negedge clk); dat_wr = 1'b0;
   endtask

   task automatic put_cell(int id);
      reg_write(8'h05);
      for (int w = 0; w < NW; w++) word_write(exp_word(id, w));
   endtask

   // Drain n cells with ids first..first+n-1 (id 255 alone for the byte cell)
   task automatic drain(int first, int n, int pat);
      for (int c = 0; c < n; c++) begin
         for (int w = 0; w < NW; w++) begin
            int guard = 0;
            bit done = 0;
            while (!done && guard < 50) begin
               @(negedge clk);
               guard++;
               out_ready = (pat == 0) ? 1'b1 : ((guard % pat) == 0);
               if (out_valid && out_ready) begin
                  check(out_data == exp_word(first + c, w), "R8 data order",
                        out_data, exp_word(first + c, w));
                  check(out_soc == (w == 0), "R7 start flag",
                        32'(out_soc), 32'(w == 0));
                  done = 1;
               end
            end
            if (!done) check(1'b0, "R7 word not offered", 32'(c), 32'(w));
         end
      end
      @(negedge clk); out_ready = 1'b0;
      check(!out_valid, "R7 empty after drain", 32'(out_valid), 0);
   endtask

   initial begin
      #(8 * 150000);
      check(1'b0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(reg_rdata == 8'h06, "R1 reset register", 32'(reg_rdata), 32'h06);
      check(!out_valid, "R1 reset valid", 32'(out_valid), 0);

      // R9: marker reads back, is consumed by the first word
      reg_write(8'h05);
      check(reg_rdata == 8'h07, "R9 marker set", 32'(reg_rdata), 32'h07);
      for (int w = 0; w < NW - 1; w++) begin
         word_write(exp_word(1, w));
         if (w == 0)
            check(reg_rdata[0] == 1'b0, "R9 marker cleared", 32'(reg_rdata[0]), 0);
      end
      check(!out_valid && !reg_rdata[4], "R2 partial hidden",
            {out_valid, reg_rdata[4]}, 0);
      word_write(exp_word(1, NW - 1));
      check(out_valid && reg_rdata[4], "R2 visible after last word",
            {out_valid, reg_rdata[4]}, 3);
      drain(1, 1, 0);

      // Sweep fill levels 1..4, each with its own ready pattern (R3, R6, R7)
      for (int k = 1; k <= ND; k++) begin
         for (int c = 0; c < k; c++) begin
            put_cell(10 * k + c);
            check(reg_rdata[1] == (c + 1 < ND), "R3 room bit",
                  32'(reg_rdata[1]), 32'(c + 1 < ND));
            check(reg_rdata[4] == 1'b1, "R3 avail bit", 32'(reg_rdata[4]), 1);
         end
         drain(10 * k, k, k);
         check(reg_rdata == 8'h06, "R3 status after drain", 32'(reg_rdata), 32'h06);
      end

      // R4: full buffer, start attempt dropped and overflow sticky
      for (int c = 0; c < ND; c++) put_cell(60 + c);
      reg_write(8'h05);
      word_write(32'hDEAD_BEEF);
      check(reg_rdata == 8'h1C, "R4 overflow on full", 32'(reg_rdata), 32'h1C);
      for (int w = 1; w < NW; w++) word_write(32'hBAD0_0000 + w);
      drain(60, ND, 2);
      check(reg_rdata == 8'h0E, "R4 overflow sticky", 32'(reg_rdata), 32'h0E);

      // R5: flush empties the store and ignores data writes meanwhile
      put_cell(70); put_cell(71);
      reg_write(8'h01);
      @(negedge clk);
      check(!out_valid, "R5 valid low in flush", 32'(out_valid), 0);
      check(reg_rdata == 8'h03, "R5 flush status", 32'(reg_rdata), 32'h03);
      for (int w = 0; w < NW; w++) word_write(exp_word(72, w));
      check(!out_valid, "R5 writes ignored in flush", 32'(out_valid), 0);
      reg_write(8'h04);
      check(!out_valid && reg_rdata == 8'h06, "R5 empty after release",
            {out_valid, 8'h0, reg_rdata}, 32'h06);
      put_cell(73);
      drain(73, 1, 0);

      // R10: marker mid-cell restarts the cell
      reg_write(8'h05);
      for (int w = 0; w < 5; w++) word_write(exp_word(80, w));
      put_cell(81);
      drain(81, 1, 3);

      // R11: words with no open cell are ignored
      for (int w = 0; w < NW; w++) word_write(exp_word(90, w));
      check(!out_valid && reg_rdata == 8'h06, "R11 stray words ignored",
            {out_valid, 8'h0, reg_rdata}, 32'h06);

      // R8: byte placement in a fully numbered cell
      put_cell(255);
      check(out_data == 32'h1011_1213, "R8 header word", out_data, 32'h1011_1213);
      drain(255, 1, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule